// File: doc/BRIEF.md
# Radix-4 Signed-Digit Multiplier Recoder

This block turns a parallel two's complement multiplier word into a stream of radix-4 signed digits for a sequential multiply datapath. A load strobe captures the word. The block then looks at it through a three-bit window that starts at the least significant end and moves up two bit positions per clock. Consecutive windows share one bit. Each window becomes one digit from the set {0, +A, +2A, -A, -2A}, and the block issues exactly `MW/2` digits, one per clock.

Each digit is delivered as three multiplexer controls for the multiple-selection stage downstream: double, negate and null. A valid strobe and a last-digit flag travel with every digit. The recoding is done in two logic levels. The first level decodes the window into one-hot selects for +2A, -A, -2A and zero. The second level folds those selects into the three controls. Digits do not depend on one another, so the only state is the shifting window and a digit counter.

Top module: `booth_digit_recoder`

## Requirements
- R1: After reset, `busy_o`, `dig_valid_o`, `dig_last_o`, `dig_double_o`, `dig_negate_o` and `dig_null_o` are all 0.
- R2: A load while `busy_o` is 0 is accepted. In the following cycle `busy_o` is 1 and `dig_valid_o` is still 0. The first digit appears one cycle after that.
- R3: The first digit uses a lookbehind bit of 0 below the least significant multiplier bit. Its window is (b1, b0, 0).
- R4: Digit k (k = 0 .. MW/2-1) recodes the window (b(2k+1), b(2k), b(2k-1)) as: 000→0, 001→+A, 010→+A, 011→+2A, 100→−2A, 101→−A, 110→−A, 111→0. The digit values, weighted by 4^k and summed, equal the signed word.
- R5: The controls encode the digit as follows. Zero is null=1, double=0, negate=0. +A is all three 0. +2A is double=1. −A is negate=1. −2A is double=1 and negate=1.
- R6: `dig_valid_o` is high for exactly MW/2 consecutive cycles per accepted load. `dig_last_o` is high only with the final digit.
- R7: A load while `busy_o` is 1 is ignored, and the digit stream already in progress is unchanged.
- R8: `busy_o` falls in the cycle that shows the last digit. A load in that cycle is accepted, and its digits follow after one empty cycle.
- R9: While `dig_valid_o` is 0, `dig_last_o` and all three controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for `mult_i` |
| mult_i | input | MW | Two's complement multiplier word |
| busy_o | output | 1 | A word is being recoded; loads are ignored |
| dig_valid_o | output | 1 | A digit is present on the controls |
| dig_last_o | output | 1 | The present digit is the final one of the word |
| dig_double_o | output | 1 | Select the doubled multiple |
| dig_negate_o | output | 1 | Select the negated multiple |
| dig_null_o | output | 1 | Select the zero multiple |

## Verification
The assertions assume that `rst_n` is held low until inputs are defined. They also assume that `load_i` and `mult_i` change only away from the rising edge. The stream checks assume that a valid run always starts from an idle output, which holds because the block cannot issue back-to-back runs without a gap. The bench drives every input on the falling edge and sweeps every 8-bit multiplier word. It varies whether a rejected load is injected mid-stream and whether the next word is loaded in the last-digit cycle. Together these keep every stimulus inside the assumed envelope while covering loads that arrive when idle, while busy, and at the boundary.

// File: rtl/booth_rec_pkg.sv
package booth_rec_pkg;

    // First-level one-hot multiple selects; +A is the case with none set.
    typedef struct packed {
        logic pos2;
        logic neg1;
        logic neg2;
        logic zero;
    } mult_sel_t;

    // Second-level controls for the multiple-selection multiplexer.
    typedef struct packed {
        logic dbl;
        logic neg;
        logic nul;
    } mux_ctrl_t;

    localparam mux_ctrl_t CTRL_IDLE = '{dbl: 1'b0, neg: 1'b0, nul: 1'b0};

endpackage

// File: rtl/booth_window_shifter.sv
module booth_window_shifter #(
    parameter int MW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [MW-1:0] mult_i,
    output logic [2:0] win_o,
    output logic       step_o,
    output logic       step_last_o,
    output logic       busy_o
);
    localparam int NDIG = MW / 2;
    localparam int CW   = $clog2(NDIG + 1);
    localparam int RW   = MW + 1;

    typedef struct packed {
        logic [RW-1:0] win;
        logic [CW-1:0] cnt;
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic       busy_w;

    assign busy_w = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (load_i && !busy_w) begin
            st_d.win = {mult_i, 1'b0};
            st_d.cnt = CW'(NDIG);
        end else if (busy_w) begin
            st_d.win = st_q.win >> 2;
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o       = st_q.win[2:0];
    assign step_o      = busy_w;
    assign step_last_o = (st_q.cnt == CW'(1));
    assign busy_o      = busy_w;

endmodule

// File: rtl/booth_select_decode.sv
module booth_select_decode
    import booth_rec_pkg::*;
(
    input  logic [2:0] win_i,
    output mult_sel_t  sel_o
);
    always_comb begin
        sel_o = '0;
        unique case (win_i)
            3'b000:  sel_o.zero = 1'b1;
            3'b001:  sel_o      = '0;
            3'b010:  sel_o      = '0;
            3'b011:  sel_o.pos2 = 1'b1;
            3'b100:  sel_o.neg2 = 1'b1;
            3'b101:  sel_o.neg1 = 1'b1;
            3'b110:  sel_o.neg1 = 1'b1;
            default: sel_o.zero = 1'b1;
        endcase
    end

endmodule

// File: rtl/booth_ctrl_merge.sv
module booth_ctrl_merge
    import booth_rec_pkg::*;
(
    input  mult_sel_t sel_i,
    output mux_ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o.dbl = sel_i.pos2 | sel_i.neg2;
        ctrl_o.neg = sel_i.neg1 | sel_i.neg2;
        ctrl_o.nul = sel_i.zero;
    end

endmodule

// File: rtl/booth_digit_recoder.sv
module booth_digit_recoder
    import booth_rec_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [MW-1:0] mult_i,
    output logic          busy_o,
    output logic          dig_valid_o,
    output logic          dig_last_o,
    output logic          dig_double_o,
    output logic          dig_negate_o,
    output logic          dig_null_o
);
    typedef struct packed {
        logic      vld;
        logic      last;
        mux_ctrl_t ctrl;
    } out_state_t;

    logic       [2:0] win_w;
    logic             step_w;
    logic             step_last_w;
    mult_sel_t        sel_w;
    mux_ctrl_t        ctrl_w;
    out_state_t       out_d, out_q;

    booth_window_shifter #(.MW(MW)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .mult_i      (mult_i),
        .win_o       (win_w),
        .step_o      (step_w),
        .step_last_o (step_last_w),
        .busy_o      (busy_o)
    );

    booth_select_decode u_lvl1 (
        .win_i (win_w),
        .sel_o (sel_w)
    );

    booth_ctrl_merge u_lvl2 (
        .sel_i  (sel_w),
        .ctrl_o (ctrl_w)
    );

    always_comb begin
        out_d      = '0;
        out_d.ctrl = CTRL_IDLE;
        if (step_w) begin
            out_d.vld  = 1'b1;
            out_d.last = step_last_w;
            out_d.ctrl = ctrl_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dig_valid_o  = out_q.vld;
    assign dig_last_o   = out_q.last;
    assign dig_double_o = out_q.ctrl.dbl;
    assign dig_negate_o = out_q.ctrl.neg;
    assign dig_null_o   = out_q.ctrl.nul;

endmodule

// File: rtl/booth_digit_recoder_chk.sv
module booth_digit_recoder_chk #(
    parameter int MW = 8
) (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic busy_o,
    input logic dig_valid_o,
    input logic dig_last_o,
    input logic dig_double_o,
    input logic dig_negate_o,
    input logic dig_null_o
);
    localparam int NDIG = MW / 2;
    localparam int CW   = $clog2(NDIG + 1);

    logic [CW-1:0] vcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q <= '0;
        end else if (dig_valid_o) begin
            vcnt_q <= dig_last_o ? '0 : vcnt_q + CW'(1);
        end
    end

    // R2: an accepted load makes the block busy before any digit shows
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> (busy_o && !dig_valid_o));

    // R5: the zero digit never selects a doubled or negated multiple
    a_r5_null_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid_o && dig_null_o) |-> (!dig_double_o && !dig_negate_o));

    // R6: last flag marks exactly the final digit of a run
    a_r6_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o |-> (dig_last_o == (vcnt_q == CW'(NDIG - 1))));

    // R6: a run ends only on its last digit
    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_valid_o) |-> $past(dig_last_o));

    // R8: busy drops together with the last digit being shown
    a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (dig_valid_o && dig_last_o));

    // R9: controls are quiet when no digit is valid
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_valid_o |-> (!dig_last_o && !dig_double_o && !dig_negate_o && !dig_null_o));

endmodule

bind booth_digit_recoder booth_digit_recoder_chk #(.MW(MW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .busy_o       (busy_o),
    .dig_valid_o  (dig_valid_o),
    .dig_last_o   (dig_last_o),
    .dig_double_o (dig_double_o),
    .dig_negate_o (dig_negate_o),
    .dig_null_o   (dig_null_o)
);

// File: tb/booth_digit_recoder_test.sv
module booth_digit_recoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int MW         = 8;
    localparam int NDIG       = MW / 2;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [MW-1:0] mult_i = '0;
    logic          busy_o, dig_valid_o, dig_last_o;
    logic          dig_double_o, dig_negate_o, dig_null_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_digit_recoder #(.MW(MW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .mult_i       (mult_i),
        .busy_o       (busy_o),
        .dig_valid_o  (dig_valid_o),
        .dig_last_o   (dig_last_o),
        .dig_double_o (dig_double_o),
        .dig_negate_o (dig_negate_o),
        .dig_null_o   (dig_null_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_digit(input logic [MW-1:0] w, input int k);
        int hi, mid, lo;
        hi  = w[2*k+1];
        mid = w[2*k];
        lo  = (k == 0) ? 0 : int'(w[2*k-1]);
        return -2 * hi + mid + lo;
    endfunction

    // Packs controls as {double, negate, null}
    function automatic int exp_ctrl(input int d);
        if (d == 0) return 1;
        return ((d == 2 || d == -2) ? 4 : 0) + ((d < 0) ? 2 : 0);
    endfunction

    function automatic int dut_digit();
        if (dig_null_o) return 0;
        return (dig_double_o ? 2 : 1) * (dig_negate_o ? -1 : 1);
    endfunction

    // Called at a falling edge; leaves at the falling edge that shows the last digit
    task automatic run_word(input logic [MW-1:0] w, input bit inject, input bit idle_after);
        int acc;
        acc = 0;
        load_i = 1'b1;
        mult_i = w;
        @(negedge clk);
        load_i = 1'b0;
        mult_i = ~w;
        check(busy_o == 1'b1, "R2", "busy after load", int'(busy_o), 1);
        check(dig_valid_o == 1'b0, "R2", "valid before first digit", int'(dig_valid_o), 0);
        for (int k = 0; k < NDIG; k++) begin
            @(negedge clk);
            load_i = 1'b0;
            check(dig_valid_o == 1'b1, "R6", "valid during run", int'(dig_valid_o), 1);
            check(dig_last_o == (k == NDIG - 1), "R6", "last flag", int'(dig_last_o),
                  int'(k == NDIG - 1));
            check(busy_o == (k != NDIG - 1), "R8", "busy during run", int'(busy_o),
                  int'(k != NDIG - 1));
            if (k == 0)
                check({dig_double_o, dig_negate_o, dig_null_o} == 3'(exp_ctrl(exp_digit(w, 0))),
                      "R3", "first digit controls",
                      int'({dig_double_o, dig_negate_o, dig_null_o}), exp_ctrl(exp_digit(w, 0)));
            else
                check({dig_double_o, dig_negate_o, dig_null_o} == 3'(exp_ctrl(exp_digit(w, k))),
                      "R5", "digit controls",
                      int'({dig_double_o, dig_negate_o, dig_null_o}), exp_ctrl(exp_digit(w, k)));
            acc += dut_digit() * (1 << (2 * k));
            if (inject && k == 0) begin
                load_i = 1'b1;   // R7: rejected load while busy
                mult_i = w ^ 8'h5A;
            end
        end
        check(acc == int'($signed(w)), "R4", "digit sum vs signed word", acc, int'($signed(w)));
        if (idle_after) begin
            @(negedge clk);
            check(dig_valid_o == 1'b0 && busy_o == 1'b0, "R9", "idle after run",
                  int'({busy_o, dig_valid_o}), 0);
            check({dig_last_o, dig_double_o, dig_negate_o, dig_null_o} == 4'b0, "R9",
                  "quiet controls when idle",
                  int'({dig_last_o, dig_double_o, dig_negate_o, dig_null_o}), 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy_o, dig_valid_o, dig_last_o, dig_double_o, dig_negate_o, dig_null_o} == 6'b0,
              "R1", "reset state",
              int'({busy_o, dig_valid_o, dig_last_o, dig_double_o, dig_negate_o, dig_null_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, dig_valid_o} == 2'b0, "R1", "idle after reset release",
              int'({busy_o, dig_valid_o}), 0);
        for (int w = 0; w < (1 << MW); w++) begin
            // R7 injection and R8 back-to-back loading vary with the word
            run_word(MW'(w), bit'(w[0] ^ w[3]), bit'(w[1]));
        end
        @(negedge clk);
        check(dig_valid_o == 1'b0 && busy_o == 1'b0, "R6", "stream ends after final word",
              int'({busy_o, dig_valid_o}), 0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

endmodule